// File: doc/BRIEF.md
# Single-Port RAM Access Arbiter

The block lets two requesters that run on unrelated clocks share one single-port synchronous RAM. A read requester (a video scan-out engine) and a write requester (a capture engine) each signal a new access by flipping a request toggle. While the toggle is in flight, the requester holds its address, and for writes its data, stable. Inside the memory clock domain each toggle passes through a two-flop synchroniser and an edge detector. The detected edge sets a pending flag that stays set until the access is taken, so a request that arrives while the RAM is busy is never lost.

A small state machine serialises the accesses onto the single address and data port. Each access holds the RAM for one issue cycle plus a programmable number of hold cycles. A hold setting of zero is raised to one, because an access with no hold is not reliable. When the access finishes, the matching done toggle flips, and the requester synchronises it back into its own clock domain. Read data is kept in an output register that changes only when a later read completes. The current state is brought out for debug. The RAM itself is a behavioural model inside the block.

Top module: `sparb_top`

## Requirements
- R1: During and after reset, accessState is 0, rdDoneTgl and wrDoneTgl are 0, rdData is 0, and no access is pending.
- R2: accessState is encoded as 0 = idle, 1 = reading, 2 = read-end, 3 = writing. A reading run is always followed by exactly one read-end cycle and then idle. A writing run is always followed by idle.
- R3: Every flip of rdReqTgl or wrReqTgl, made while the previous request on that side is complete, produces exactly one flip of the matching done toggle. This holds even when the request arrives while the other side's access is in progress.
- R4: When a read and a write are both pending while the machine is idle, the read is served first and the write follows.
- R5: Each reading or writing run lasts 1 + H memory-clock cycles. H is holdCycles, sampled when the access starts, and a holdCycles value of 0 gives H = 1.
- R6: A write stores wrData at wrAddr. wrDoneTgl flips on the clock edge where the machine leaves the writing state.
- R7: A read loads rdData with the RAM word at rdAddr on the read-end cycle, and rdDoneTgl flips on that same edge. rdData then stays unchanged, including across writes to the same address, until the next read completes.
- R8: The requester keeps its address and write data stable from its request toggle until it sees the matching done toggle. The RAM is DEPTH words of DATA_W bits, addressed by ADDR_W = log2(DEPTH) bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| memClk | input | 1 | Memory and arbiter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| holdCycles | input | HOLD_W | Extra hold cycles per access (0 treated as 1) |
| rdReqTgl | input | 1 | Read request toggle, from the read requester's clock domain |
| rdAddr | input | ADDR_W | Read address, stable while a read is in flight |
| rdData | output | DATA_W | Registered read result |
| rdDoneTgl | output | 1 | Read completion toggle |
| wrReqTgl | input | 1 | Write request toggle, from the write requester's clock domain |
| wrAddr | input | ADDR_W | Write address, stable while a write is in flight |
| wrData | input | DATA_W | Write data, stable while a write is in flight |
| wrDoneTgl | output | 1 | Write completion toggle |
| accessState | output | 2 | Debug copy of the access state |

## Verification
A lost pending flag shows up at the ports as a done toggle that never flips. The requester's wait then runs out within a few hundred of its own cycles. A hold counter that is off by one shows on accessState as a reading or writing run of the wrong length, and the bench sees this on the first access after the fault. A wrong RAM address or capture cycle gives a read result that disagrees with the scoreboard of earlier writes on the very next read. A swapped priority shows as a writing run that starts before the reading run on the first simultaneous request.

// File: rtl/sparb_pkg.sv
`timescale 1ns/1ps
package sparb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_RD_END = 2'd2,
    ST_WRITE  = 2'd3
  } arb_state_e;

  typedef struct packed {
    logic selWrite;  // address mux picks the write side
    logic wrEn;      // RAM write enable
    logic capRead;   // load the read output register
  } arb_strobe_t;

endpackage

// File: rtl/sparb_toggle_sync.sv
`timescale 1ns/1ps
module sparb_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tglIn,
  output logic pulse
);
  logic [STAGES:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else       shReg <= {shReg[STAGES-1:0], tglIn};
  end

  assign pulse = shReg[STAGES] ^ shReg[STAGES-1];
endmodule

// File: rtl/sparb_ctrl.sv
`timescale 1ns/1ps
module sparb_ctrl
  import sparb_pkg::*;
#(
  parameter int HOLD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HOLD_W-1:0] holdCycles,
  input  logic              rdReqTgl,
  input  logic              wrReqTgl,
  output arb_strobe_t       strobe,
  output arb_state_e        state,
  output logic              rdDoneTgl,
  output logic              wrDoneTgl
);
  localparam int NUM_CH = 2;   // index 0 = read, 1 = write

  logic [NUM_CH-1:0] reqTgl, reqEdge;
  assign reqTgl = {wrReqTgl, rdReqTgl};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sync
    sparb_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rstN  (rstN),
      .tglIn (reqTgl[ch]),
      .pulse (reqEdge[ch])
    );
  end

  logic              rdPend, wrPend;
  logic              takeRd, takeWr;
  logic [HOLD_W-1:0] holdLat, holdEff, cnt;
  logic              cntDone;
  arb_state_e        nextState;

  assign holdEff = (holdCycles == '0) ? HOLD_W'(1) : holdCycles;
  assign takeRd  = (state == ST_IDLE) && rdPend;
  assign takeWr  = (state == ST_IDLE) && !rdPend && wrPend;
  assign cntDone = (cnt == holdLat);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (takeRd)      nextState = ST_READ;
        else if (takeWr) nextState = ST_WRITE;
      end
      ST_READ:   if (cntDone) nextState = ST_RD_END;
      ST_RD_END: nextState = ST_IDLE;
      ST_WRITE:  if (cntDone) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rdPend    <= 1'b0;
      wrPend    <= 1'b0;
      holdLat   <= HOLD_W'(1);
      cnt       <= '0;
      rdDoneTgl <= 1'b0;
      wrDoneTgl <= 1'b0;
    end else begin
      state  <= nextState;
      rdPend <= reqEdge[0] | (rdPend & !takeRd);
      wrPend <= reqEdge[1] | (wrPend & !takeWr);
      if (takeRd || takeWr) begin
        holdLat <= holdEff;
        cnt     <= '0;
      end else if (state == ST_READ || state == ST_WRITE) begin
        cnt <= cnt + HOLD_W'(1);
      end
      if (state == ST_RD_END)            rdDoneTgl <= ~rdDoneTgl;
      if (state == ST_WRITE && cntDone)  wrDoneTgl <= ~wrDoneTgl;
    end
  end

  assign strobe.selWrite = (state == ST_WRITE);
  assign strobe.wrEn     = (state == ST_WRITE) && (cnt == '0);
  assign strobe.capRead  = (state == ST_RD_END);

  // ---------------- assertions ----------------
  logic [HOLD_W:0] accLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accLen <= '0;
    else if (state == ST_READ || state == ST_WRITE) accLen <= accLen + 1'b1;
    else accLen <= '0;
  end

  assert_min_hold_rd_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_END && $past(state) == ST_READ) |-> accLen >= 2);
  assert_min_hold_wr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_WRITE) |-> accLen >= 2);
  assert_rd_end_next_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_END) |=> (state == ST_IDLE));
  assert_read_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && rdPend && wrPend) |=> (state == ST_READ));
  assert_rd_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdPend && state != ST_IDLE) |=> rdPend);
  assert_wr_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrPend && !(state == ST_IDLE && !rdPend)) |=> wrPend);
  assert_rd_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdDoneTgl) |-> ($past(state) == ST_RD_END));
  assert_wr_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wrDoneTgl) |-> ($past(state) == ST_WRITE && state == ST_IDLE));
endmodule

// File: rtl/sparb_datapath.sv
`timescale 1ns/1ps
module sparb_datapath
  import sparb_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  arb_strobe_t       strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ramQ;
  logic [ADDR_W-1:0] ramAddr;

  assign ramAddr = strobe.selWrite ? wrAddr : rdAddr;

  // behavioural single-port RAM, registered output
  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[ramAddr] <= wrData;
    ramQ <= mem[ramAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strobe.capRead) rdData <= ramQ;
  end

  assert_we_only_writing_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> strobe.selWrite);
  assert_no_cap_while_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capRead && strobe.selWrite));
endmodule

// File: rtl/sparb_top.sv
`timescale 1ns/1ps
module sparb_top
  import sparb_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int DATA_W      = 128,
  parameter int HOLD_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              memClk,
  input  logic              rstN,
  input  logic [HOLD_W-1:0] holdCycles,
  input  logic              rdReqTgl,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDoneTgl,
  input  logic              wrReqTgl,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrDoneTgl,
  output logic [1:0]        accessState
);
  arb_strobe_t strobe;
  arb_state_e  state;

  sparb_ctrl #(.HOLD_W(HOLD_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (memClk),
    .rstN       (rstN),
    .holdCycles (holdCycles),
    .rdReqTgl   (rdReqTgl),
    .wrReqTgl   (wrReqTgl),
    .strobe     (strobe),
    .state      (state),
    .rdDoneTgl  (rdDoneTgl),
    .wrDoneTgl  (wrDoneTgl)
  );

  sparb_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk    (memClk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdAddr (rdAddr),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdData (rdData)
  );

  assign accessState = state;
endmodule

// File: tb/sparb_top_tb_top.sv
`timescale 1ns/1ps
module sparb_top_tb_top;
  localparam int DEPTH = 128, DATA_W = 128, HOLD_W = 4, ADDR_W = 7;

  logic memClk = 0, rdClk = 0, wrClk = 0, rstN = 0;
  logic [HOLD_W-1:0] holdCycles = '0;
  logic rdReqTgl = 0, wrReqTgl = 0;
  logic [ADDR_W-1:0] rdAddr = '0, wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic rdDoneTgl, wrDoneTgl;
  logic [1:0] accessState;

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] sb [DEPTH];
  bit sbValid [DEPTH];

  sparb_top #(.DEPTH(DEPTH), .DATA_W(DATA_W), .HOLD_W(HOLD_W)) dut_i (
    .memClk(memClk), .rstN(rstN), .holdCycles(holdCycles),
    .rdReqTgl(rdReqTgl), .rdAddr(rdAddr), .rdData(rdData), .rdDoneTgl(rdDoneTgl),
    .wrReqTgl(wrReqTgl), .wrAddr(wrAddr), .wrData(wrData), .wrDoneTgl(wrDoneTgl),
    .accessState(accessState)
  );

  always #4     memClk = ~memClk;   // 125 MHz
  always #12.5  rdClk  = ~rdClk;    // 40 MHz
  always #18.75 wrClk  = ~wrClk;    // ~26.67 MHz

  // done toggles synchronised into each requester's domain
  logic rdDs1 = 0, rdDs2 = 0, wrDs1 = 0, wrDs2 = 0;
  always_ff @(posedge rdClk) begin rdDs1 <= rdDoneTgl; rdDs2 <= rdDs1; end
  always_ff @(posedge wrClk) begin wrDs1 <= wrDoneTgl; wrDs2 <= wrDs1; end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int effHold(input logic [HOLD_W-1:0] h);
    return (h == 0) ? 1 : int'(h);
  endfunction

  function automatic logic [DATA_W-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // ---------- state monitor: R2, R4, R5 ----------
  logic [1:0] prevState = 2'd0;
  int runLen = 0;
  int logIdx = 0;
  logic [1:0] startLog [2];
  always @(negedge memClk) begin
    if (rstN) begin
      if (accessState != prevState) begin
        if (prevState == 2'd1 || prevState == 2'd3)
          chk(runLen == effHold(holdCycles) + 1, "R5", "access run length",
              DATA_W'(runLen), DATA_W'(effHold(holdCycles) + 1));
        if (prevState == 2'd1)
          chk(accessState == 2'd2, "R2", "state after reading", DATA_W'(accessState), 2);
        if (prevState == 2'd2 || prevState == 2'd3)
          chk(accessState == 2'd0, "R2", "state after read-end/writing", DATA_W'(accessState), 0);
        if (accessState == 2'd1 || accessState == 2'd3) begin
          runLen = 1;
          if (logIdx < 2) startLog[logIdx] = accessState;
          logIdx++;
        end
      end else if (accessState == 2'd1 || accessState == 2'd3) begin
        runLen++;
      end
      prevState = accessState;
    end
  end

  task automatic doWrite(input int addr, input logic [DATA_W-1:0] d);
    int n = 0;
    @(posedge wrClk);
    wrAddr <= ADDR_W'(addr); wrData <= d; wrReqTgl <= ~wrReqTgl;
    @(negedge wrClk);
    while (wrDs2 != wrReqTgl && n < 400) begin @(negedge wrClk); n++; end
    chk(wrDs2 == wrReqTgl, "R3", "write done toggle", DATA_W'(wrDs2), DATA_W'(wrReqTgl));
    sb[addr] = d; sbValid[addr] = 1'b1;
  endtask

  task automatic doRead(input int addr, output logic [DATA_W-1:0] q);
    int n = 0;
    @(posedge rdClk);
    rdAddr <= ADDR_W'(addr); rdReqTgl <= ~rdReqTgl;
    @(negedge rdClk);
    while (rdDs2 != rdReqTgl && n < 400) begin @(negedge rdClk); n++; end
    chk(rdDs2 == rdReqTgl, "R3", "read done toggle", DATA_W'(rdDs2), DATA_W'(rdReqTgl));
    q = rdData;
    if (sbValid[addr]) chk(q == sb[addr], "R7", "read data vs scoreboard", q, sb[addr]);
  endtask

  // watchdog
  initial begin
    #(8.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] q, kept, pv;
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) sbValid[i] = 1'b0;

    repeat (5) @(posedge memClk);
    @(negedge memClk);
    chk(accessState == 2'd0, "R1", "reset state", DATA_W'(accessState), 0);
    chk(rdData == '0, "R1", "reset read data", rdData, 0);
    chk(rdDoneTgl == 1'b0 && wrDoneTgl == 1'b0, "R1", "reset done toggles",
        DATA_W'({rdDoneTgl, wrDoneTgl}), 0);
    rstN = 1;
    repeat (10) @(negedge memClk);
    chk(accessState == 2'd0, "R1", "idle with no request", DATA_W'(accessState), 0);

    // preload with hold 0 (treated as 1): R5, R6, R8
    holdCycles = 4'd0;
    for (int a = 0; a < 64; a++) doWrite(a, rnd128());

    // directed: read stability across a write to the same address (R7)
    holdCycles = 4'd15;
    doRead(5, kept);
    doWrite(5, rnd128());
    repeat (4) @(negedge rdClk);
    chk(rdData == kept, "R7", "read data held across write", rdData, kept);
    doRead(5, q);
    chk(q == sb[5], "R6", "write landed at address", q, sb[5]);

    // concurrent random traffic from both domains (R3, R6, R7)
    holdCycles = 4'd3;
    fork
      begin
        for (int i = 0; i < 40; i++) doRead($urandom_range(0, 63), q);
      end
      begin
        for (int i = 0; i < 40; i++) doWrite($urandom_range(64, 127), rnd128());
      end
    join

    // simultaneous requests from idle: read first (R4)
    holdCycles = 4'd2;
    repeat (10) @(negedge memClk);
    logIdx = 0;
    pv = rnd128();
    @(negedge memClk);
    rdAddr = 7'd10; wrAddr = 7'd11; wrData = pv;
    rdReqTgl = ~rdReqTgl; wrReqTgl = ~wrReqTgl;
    n = 0;
    while ((rdDs2 != rdReqTgl || wrDs2 != wrReqTgl) && n < 400) begin @(negedge wrClk); n++; end
    chk(rdDs2 == rdReqTgl && wrDs2 == wrReqTgl, "R3", "both done after simultaneous request",
        DATA_W'({rdDs2, wrDs2}), DATA_W'({rdReqTgl, wrReqTgl}));
    chk(logIdx == 2, "R4", "two accesses started", DATA_W'(logIdx), 2);
    chk(startLog[0] == 2'd1, "R4", "first access is read", DATA_W'(startLog[0]), 1);
    chk(startLog[1] == 2'd3, "R4", "second access is write", DATA_W'(startLog[1]), 3);
    chk(rdData == sb[10], "R7", "priority read data", rdData, sb[10]);
    sb[11] = pv; sbValid[11] = 1'b1;
    doRead(11, q);

    // read back every written upper address (R6)
    holdCycles = 4'd1;
    for (int a = 64; a < DEPTH; a++) if (sbValid[a]) doRead(a, q);

    repeat (20) @(negedge memClk);
    chk(rdDoneTgl == rdReqTgl, "R3", "one read done per request", DATA_W'(rdDoneTgl), DATA_W'(rdReqTgl));
    chk(wrDoneTgl == wrReqTgl, "R3", "one write done per request", DATA_W'(wrDoneTgl), DATA_W'(wrReqTgl));
    chk(accessState == 2'd0, "R2", "idle at end", DATA_W'(accessState), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule